// File: doc/BRIEF.md
# Pipelined Burst-Capable Bus Master

This block sits between a processor core and a pipelined system bus with a 64-bit data path, and it is a bus master only. The core hands it one request at a time. Each request carries a kind, an address, a size and, for writes, data already placed on its byte lanes. The kind picks the transfer shape. Uncached reads, uncached writes and write-buffer drains become one-beat transfers. Line fills and copybacks become four-beat bursts of doublewords.

Bus transfers are split into an address phase and a data phase. The address phase of a following transfer can be accepted while an earlier data phase is still running. At most one accepted address may wait behind the active data phase. Every data beat that completes is reported back to the core with its beat index. A bus error ends the transfer that is in progress. A single-beat request whose bytes would run past an 8-byte boundary never reaches the bus; the block flags it at once instead.

Top module: `burst_bus_master`

## Requirements
- R1: The request kind selects the transfer shape: 0 uncached read, 1 uncached write and 2 write-buffer write each give one beat, with `bus_burst`=0 and a single response that has `rsp_last`=1. Kind 3 (line fill) and kind 4 (copyback) each give a four-beat burst with `bus_burst`=1. Kinds 1, 2 and 4 drive `bus_write`=1.
- R2: A burst address phase carries the request address with its low 5 bits cleared, `bus_size`=4 and `bus_be`=8'hFF.
- R3: Burst beats complete in linear order 0,1,2,3. `rsp_beat` gives the index of each beat, `rsp_rdata` passes that beat's read data, and `rsp_last` is set only on the final beat.
- R4: The size codes 0, 1, 2, 3 and 4 mean 1, 2, 3, 4 and 8 bytes. For a single beat, `bus_be` bit i enables the byte at offset i within the doubleword. The enabled bits are contiguous and start at bit `addr[2:0]`.
- R5: A single-beat request with `addr[2:0]` + bytes > 8 is accepted with `req_misalign`=1 in its handshake cycle and produces no address phase.
- R6: While `bus_avalid` is high and `bus_aready` is low, the address phase stays valid and its address and byte enables do not change.
- R7: The next transfer's address phase can be accepted while the previous transfer's data phase has not yet completed.
- R8: At most one accepted address waits beyond the active data phase. A further address phase stays pending until that data phase ends.
- R9: A bus error on any beat sets `rsp_err` and `rsp_last` on that beat and ends the transfer, so the remaining burst beats are dropped. The next transfer is unaffected.
- R10: A single-beat write drives its request data on `bus_wdata`. A copyback drives `cb_wdata` on `bus_wdata`, with `cb_beat` giving the beat index being written.
- R11: Out of reset, `req_ready`=1, `bus_avalid`=0 and `rsp_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Request slot can take a request |
| req_kind | input | 3 | Request kind (R1 encoding) |
| req_addr | input | AW (32) | Byte address |
| req_size | input | 3 | Size code (R4 encoding) |
| req_wdata | input | 64 | Lane-aligned write data for single writes |
| req_misalign | output | 1 | Request rejected as crossing a doubleword |
| cb_beat | output | BW (2) | Beat index whose copyback data is needed |
| cb_wdata | input | 64 | Copyback data for beat `cb_beat` |
| bus_avalid | output | 1 | Address phase valid |
| bus_aready | input | 1 | Bus takes the address phase |
| bus_addr | output | AW (32) | Transfer address |
| bus_write | output | 1 | Transfer is a write |
| bus_burst | output | 1 | Transfer is a four-beat burst |
| bus_size | output | 3 | Transfer size code |
| bus_be | output | 8 | Byte-lane enables |
| bus_dready | input | 1 | Current data beat completes |
| bus_wdata | output | 64 | Write data for the current beat |
| bus_rdata | input | 64 | Read data for the current beat |
| bus_err | input | 1 | Error response on the current beat |
| rsp_valid | output | 1 | A data beat completed |
| rsp_write | output | 1 | Completed beat belongs to a write |
| rsp_beat | output | BW (2) | Index of the completed beat |
| rsp_rdata | output | 64 | Read data of the completed beat |
| rsp_last | output | 1 | Transfer finished on this beat |
| rsp_err | output | 1 | Beat ended with a bus error |

## Verification
Two functions can fall in the same cycle. One is the acceptance of a new address phase. The other is the completion of the data phase ahead of it, which frees the queued slot in that same cycle. The bench provokes this by stalling the data beats of a line fill while an uncached read and a third request are issued behind it. The third address must stay pending, and only two address phases may be accepted while no beat has completed. When the stall is released, the third address has to be accepted as the fill drains. The responses must then arrive fill beats first, in order, followed by the read and then the third transfer.

// File: rtl/burst_bus_master.sv
module burst_bus_master #(
  parameter int AW        = 32,
  parameter int BURST_LEN = 4,
  localparam int BW       = $clog2(BURST_LEN),
  localparam int LINE_B   = BURST_LEN * 8,
  localparam int OFF_W    = $clog2(LINE_B)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_kind,
  input  logic [AW-1:0] req_addr,
  input  logic [2:0]    req_size,
  input  logic [63:0]   req_wdata,
  output logic          req_misalign,
  output logic [BW-1:0] cb_beat,
  input  logic [63:0]   cb_wdata,
  output logic          bus_avalid,
  input  logic          bus_aready,
  output logic [AW-1:0] bus_addr,
  output logic          bus_write,
  output logic          bus_burst,
  output logic [2:0]    bus_size,
  output logic [7:0]    bus_be,
  input  logic          bus_dready,
  output logic [63:0]   bus_wdata,
  input  logic [63:0]   bus_rdata,
  input  logic          bus_err,
  output logic          rsp_valid,
  output logic          rsp_write,
  output logic [BW-1:0] rsp_beat,
  output logic [63:0]   rsp_rdata,
  output logic          rsp_last,
  output logic          rsp_err
);

  typedef struct packed {
    logic [AW-1:0] addr;
    logic          write;
    logic          burst;
    logic [2:0]    size;
    logic [7:0]    be;
    logic [63:0]   wdata;
  } xfer_t;

  xfer_t          nx, a_x, q_x, d_x;
  logic           a_v, q_v, d_v;
  logic [BW-1:0]  d_beat;
  logic [3:0]     nbytes, span;
  logic           is_burst, is_write, mis;
  logic           accept, d_last, d_done, free_d, load_a;

  always_comb begin
    case (req_size)
      3'd0:    nbytes = 4'd1;
      3'd1:    nbytes = 4'd2;
      3'd2:    nbytes = 4'd3;
      3'd3:    nbytes = 4'd4;
      default: nbytes = 4'd8;
    endcase
  end

  assign is_burst = (req_kind == 3'd3) || (req_kind == 3'd4);
  assign is_write = (req_kind == 3'd1) || (req_kind == 3'd2) || (req_kind == 3'd4);
  assign span     = {1'b0, req_addr[2:0]} + nbytes;
  assign mis      = !is_burst && (span > 4'd8);

  always_comb begin
    nx.write = is_write;
    nx.burst = is_burst;
    nx.wdata = req_wdata;
    if (is_burst) begin
      nx.addr = {req_addr[AW-1:OFF_W], {OFF_W{1'b0}}};
      nx.size = 3'd4;
      nx.be   = 8'hFF;
    end else begin
      nx.addr = req_addr;
      nx.size = req_size;
      nx.be   = (8'hFF >> (4'd8 - nbytes)) << req_addr[2:0];
    end
  end

  assign d_last     = d_x.burst ? (d_beat == BW'(BURST_LEN - 1)) : 1'b1;
  assign d_done     = d_v && bus_dready && (bus_err || d_last);
  assign free_d     = !d_v || d_done;
  assign bus_avalid = a_v && (!q_v || d_done);
  assign accept     = bus_avalid && bus_aready;

  assign req_ready    = !a_v || accept;
  assign load_a       = req_valid && req_ready && !mis;
  assign req_misalign = req_valid && req_ready && mis;

  assign bus_addr  = a_x.addr;
  assign bus_write = a_x.write;
  assign bus_burst = a_x.burst;
  assign bus_size  = a_x.size;
  assign bus_be    = a_x.be;

  assign cb_beat   = d_beat;
  assign bus_wdata = (d_x.burst && d_x.write) ? cb_wdata : d_x.wdata;

  assign rsp_valid = d_v && bus_dready;
  assign rsp_write = d_x.write;
  assign rsp_beat  = d_beat;
  assign rsp_rdata = bus_rdata;
  assign rsp_last  = d_done;
  assign rsp_err   = d_v && bus_dready && bus_err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_v    <= 1'b0;
      q_v    <= 1'b0;
      d_v    <= 1'b0;
      d_beat <= '0;
      a_x    <= '0;
      q_x    <= '0;
      d_x    <= '0;
    end else begin
      if (load_a) begin
        a_v <= 1'b1;
        a_x <= nx;
      end else if (accept) begin
        a_v <= 1'b0;
      end

      if (free_d) begin
        d_beat <= '0;
        if (q_v) begin
          d_v <= 1'b1;
          d_x <= q_x;
        end else if (accept) begin
          d_v <= 1'b1;
          d_x <= a_x;
        end else begin
          d_v <= 1'b0;
        end
      end else if (bus_dready) begin
        d_beat <= d_beat + 1'b1;
      end

      if (q_v) begin
        if (free_d) begin
          q_v <= accept;
          q_x <= a_x;
        end
      end else if (accept && !free_d) begin
        q_v <= 1'b1;
        q_x <= a_x;
      end
    end
  end

endmodule

// File: rtl/burst_bus_master_chk.sv
module burst_bus_master_chk #(
  parameter int AW = 32,
  parameter int BW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_misalign,
  input logic          bus_avalid,
  input logic          bus_aready,
  input logic [AW-1:0] bus_addr,
  input logic          bus_burst,
  input logic [2:0]    bus_size,
  input logic [7:0]    bus_be,
  input logic          rsp_valid,
  input logic [BW-1:0] rsp_beat,
  input logic          rsp_last,
  input logic          rsp_err
);

  logic [2:0]    outstanding;
  logic [BW-1:0] exp_beat;
  logic [3:0]    exp_ones;

  always_comb begin
    case (bus_size)
      3'd0:    exp_ones = 4'd1;
      3'd1:    exp_ones = 4'd2;
      3'd2:    exp_ones = 4'd3;
      3'd3:    exp_ones = 4'd4;
      default: exp_ones = 4'd8;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outstanding <= '0;
      exp_beat    <= '0;
    end else begin
      outstanding <= outstanding + 3'(bus_avalid && bus_aready) - 3'(rsp_valid && rsp_last);
      if (rsp_valid) exp_beat <= rsp_last ? '0 : exp_beat + 1'b1;
    end
  end

  AST_BURST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_avalid && bus_burst |-> bus_addr[4:0] == 5'd0 && bus_be == 8'hFF && bus_size == 3'd4); // R2
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_avalid && !bus_aready |=> bus_avalid && $stable(bus_addr) && $stable(bus_be)); // R6
  AST_OUTSTANDING_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding <= 3'd2); // R8
  AST_ERR_IS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> rsp_last); // R9
  AST_BEAT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_beat == exp_beat); // R3
  AST_BE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    bus_avalid && !bus_burst |-> $countones(bus_be) == 32'(exp_ones)); // R4
  AST_MISALIGN_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
    req_misalign |-> req_valid && req_ready); // R5

endmodule

bind burst_bus_master burst_bus_master_chk #(.AW(AW), .BW(BW)) u_chk (.*);

// File: tb/burst_bus_master_tb.sv
module burst_bus_master_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_kind = '0;
  logic [31:0] req_addr = '0;
  logic [2:0]  req_size = '0;
  logic [63:0] req_wdata = '0;
  logic        req_misalign;
  logic [1:0]  cb_beat;
  logic [63:0] cb_wdata;
  logic        bus_avalid, bus_aready = 1'b1;
  logic [31:0] bus_addr;
  logic        bus_write, bus_burst;
  logic [2:0]  bus_size;
  logic [7:0]  bus_be;
  logic        bus_dready = 1'b0;
  logic [63:0] bus_wdata;
  logic [63:0] bus_rdata = '0;
  logic        bus_err = 1'b0;
  logic        rsp_valid, rsp_write, rsp_last, rsp_err;
  logic [1:0]  rsp_beat;
  logic [63:0] rsp_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign cb_wdata = {32'hC0B0_0000, 30'd0, cb_beat};

  burst_bus_master u_dut (.*);

  int n_chk = 0, n_fail = 0;

  // bench-side records
  logic [31:0] acc_addr [64];
  logic [7:0]  acc_be   [64];
  logic        acc_wr   [64];
  logic        acc_bst  [64];
  logic [2:0]  acc_sz   [64];
  int          acc_n = 0;
  logic [1:0]  r_beat [64];
  logic [63:0] r_data [64];
  logic        r_last [64];
  logic        r_err  [64];
  logic        r_wr   [64];
  int          r_n = 0;
  logic [63:0] w_data [64];
  int          w_n = 0;

  // slave model state
  logic [31:0] sq_a [16];
  logic        sq_b [16];
  logic        sq_w [16];
  int          sq_i [16];
  int          sq_h = 0, sq_t = 0, sb = 0;
  bit          aready_en = 1'b1, dready_en = 1'b1;
  int          err_tr = -1, err_beat = 0;

  function automatic logic [63:0] rd_pat(input logic [31:0] a, input int b);
    return {a, 24'hD00D00, 6'd0, 2'(b)};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      bus_aready = aready_en;
      bus_dready = dready_en && (sq_h != sq_t);
      bus_rdata  = rd_pat(sq_a[sq_h % 16], sb);
      bus_err    = bus_dready && (sq_i[sq_h % 16] == err_tr) && (sb == err_beat);
      #1;
      if (rst_n) begin
        if (bus_dready) begin
          if (sq_w[sq_h % 16]) begin w_data[w_n % 64] = bus_wdata; w_n++; end
          if (bus_err || sb == (sq_b[sq_h % 16] ? 3 : 0)) begin sq_h++; sb = 0; end
          else sb++;
        end
        if (bus_avalid && bus_aready) begin
          acc_addr[acc_n % 64] = bus_addr; acc_be[acc_n % 64] = bus_be;
          acc_wr[acc_n % 64] = bus_write; acc_bst[acc_n % 64] = bus_burst;
          acc_sz[acc_n % 64] = bus_size;
          sq_a[sq_t % 16] = bus_addr; sq_b[sq_t % 16] = bus_burst;
          sq_w[sq_t % 16] = bus_write; sq_i[sq_t % 16] = acc_n;
          sq_t++; acc_n++;
        end
        if (rsp_valid) begin
          r_beat[r_n % 64] = rsp_beat; r_data[r_n % 64] = rsp_rdata;
          r_last[r_n % 64] = rsp_last; r_err[r_n % 64] = rsp_err;
          r_wr[r_n % 64] = rsp_write; r_n++;
        end
      end
    end
  end

  task automatic send(input logic [2:0] k, input logic [31:0] a, input logic [2:0] s,
                      input logic [63:0] wd, output bit mis);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_addr = a; req_size = s; req_wdata = wd;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    mis = req_misalign;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic wait_rsp(input int target);
    int guard = 0;
    while (r_n < target && guard < 200) begin @(negedge clk); guard++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    #2;
    chk(req_ready == 1'b1, "R11 req_ready", 64'(req_ready), 64'd1);
    chk(bus_avalid == 1'b0, "R11 bus_avalid", 64'(bus_avalid), 64'd0);
    chk(rsp_valid == 1'b0, "R11 rsp_valid", 64'(rsp_valid), 64'd0);
  endtask

  task automatic t_single_read;
    int a0 = acc_n, r0 = r_n; bit m;
    send(3'd0, 32'h0000_1004, 3'd3, '0, m);
    wait_rsp(r0 + 1);
    chk(acc_addr[a0] == 32'h1004, "R1 read addr", 64'(acc_addr[a0]), 64'h1004);
    chk(acc_bst[a0] == 1'b0 && acc_wr[a0] == 1'b0, "R1 read shape", {acc_bst[a0], acc_wr[a0]}, 64'd0);
    chk(acc_be[a0] == 8'hF0, "R4 be word", 64'(acc_be[a0]), 64'hF0);
    chk(r_n - r0 == 1 && r_last[r0], "R1 one beat last", 64'(r_n - r0), 64'd1);
    chk(r_data[r0] == rd_pat(32'h1004, 0), "R3 read data", r_data[r0], rd_pat(32'h1004, 0));
  endtask

  task automatic t_writes;
    int a0 = acc_n, w0 = w_n, r0 = r_n; bit m;
    send(3'd1, 32'h0000_2005, 3'd2, 64'h1122_3344_5566_7788, m);
    wait_rsp(r0 + 1);
    chk(m == 1'b0, "R5 tri ok", 64'(m), 64'd0);
    chk(acc_be[a0] == 8'hE0, "R4 be tri", 64'(acc_be[a0]), 64'hE0);
    chk(acc_wr[a0] && !acc_bst[a0], "R1 write shape", {acc_wr[a0], acc_bst[a0]}, 64'b10);
    chk(w_data[w0] == 64'h1122_3344_5566_7788, "R10 single wdata", w_data[w0], 64'h1122_3344_5566_7788);
    chk(r_wr[r0] && r_last[r0], "R1 write rsp", {r_wr[r0], r_last[r0]}, 64'b11);
    send(3'd2, 32'h0000_3002, 3'd1, 64'h0, m);
    send(3'd2, 32'h0000_3007, 3'd0, 64'h0, m);
    send(3'd1, 32'h0000_3008, 3'd4, 64'h0, m);
    wait_rsp(r0 + 4);
    chk(acc_be[a0+1] == 8'h0C, "R4 be half", 64'(acc_be[a0+1]), 64'h0C);
    chk(acc_be[a0+2] == 8'h80, "R4 be byte", 64'(acc_be[a0+2]), 64'h80);
    chk(acc_be[a0+3] == 8'hFF, "R4 be dword", 64'(acc_be[a0+3]), 64'hFF);
    chk(!acc_bst[a0+1] && acc_wr[a0+1], "R1 wb single", {acc_bst[a0+1], acc_wr[a0+1]}, 64'b01);
  endtask

  task automatic t_misalign;
    int a0 = acc_n; bit m;
    send(3'd0, 32'h0000_2006, 3'd2, '0, m);
    chk(m == 1'b1, "R5 tri cross flag", 64'(m), 64'd1);
    send(3'd1, 32'h0000_200E, 3'd3, '0, m);
    chk(m == 1'b1, "R5 word cross flag", 64'(m), 64'd1);
    repeat (5) @(negedge clk);
    chk(acc_n == a0, "R5 no address phase", 64'(acc_n - a0), 64'd0);
  endtask

  task automatic t_fill;
    int a0 = acc_n, r0 = r_n; bit m;
    send(3'd3, 32'h0004_0038, 3'd0, '0, m);
    wait_rsp(r0 + 4);
    chk(acc_addr[a0] == 32'h0004_0020, "R2 fill base", 64'(acc_addr[a0]), 64'h40020);
    chk(acc_bst[a0] && acc_sz[a0] == 3'd4 && acc_be[a0] == 8'hFF, "R2 fill shape",
        {acc_bst[a0], acc_sz[a0], acc_be[a0]}, {1'b1, 3'd4, 8'hFF});
    chk(r_n - r0 == 4, "R1 fill beats", 64'(r_n - r0), 64'd4);
    for (int b = 0; b < 4; b++) begin
      chk(r_beat[r0+b] == 2'(b), "R3 fill index", 64'(r_beat[r0+b]), 64'(b));
      chk(r_data[r0+b] == rd_pat(32'h40020, b), "R3 fill data", r_data[r0+b], rd_pat(32'h40020, b));
      chk(r_last[r0+b] == (b == 3), "R3 fill last", 64'(r_last[r0+b]), 64'(b == 3));
    end
  endtask

  task automatic t_copyback;
    int a0 = acc_n, w0 = w_n, r0 = r_n; bit m;
    send(3'd4, 32'h0000_5010, 3'd0, '0, m);
    wait_rsp(r0 + 4);
    chk(acc_addr[a0] == 32'h5000 && acc_wr[a0] && acc_bst[a0], "R1 copyback shape",
        64'(acc_addr[a0]), 64'h5000);
    for (int b = 0; b < 4; b++)
      chk(w_data[w0+b] == {32'hC0B0_0000, 30'd0, 2'(b)}, "R10 copyback wdata",
          w_data[w0+b], {32'hC0B0_0000, 30'd0, 2'(b)});
  endtask

  task automatic t_hold;
    int a0 = acc_n, r0 = r_n; bit m;
    logic [31:0] first;
    aready_en = 1'b0;
    send(3'd0, 32'h0000_6010, 3'd3, '0, m);
    @(negedge clk); #1; first = bus_addr;
    repeat (3) @(negedge clk);
    #1;
    chk(bus_avalid == 1'b1, "R6 avalid held", 64'(bus_avalid), 64'd1);
    chk(bus_addr == first && bus_addr == 32'h6010, "R6 addr held", 64'(bus_addr), 64'h6010);
    chk(acc_n == a0, "R6 nothing taken", 64'(acc_n - a0), 64'd0);
    aready_en = 1'b1;
    wait_rsp(r0 + 1);
  endtask

  task automatic t_pipeline;
    int a0 = acc_n, r0 = r_n; bit m;
    dready_en = 1'b0;
    send(3'd3, 32'h0000_7000, 3'd0, '0, m);
    send(3'd0, 32'h0000_8008, 3'd4, '0, m);
    send(3'd0, 32'h0000_9000, 3'd4, '0, m);
    repeat (5) @(negedge clk);
    #1;
    chk(acc_n - a0 == 2 && r_n == r0, "R7 overlap", 64'(acc_n - a0), 64'd2);
    chk(bus_avalid == 1'b0, "R8 third held", 64'(bus_avalid), 64'd0);
    dready_en = 1'b1;
    wait_rsp(r0 + 6);
    chk(acc_n - a0 == 3, "R8 third issued", 64'(acc_n - a0), 64'd3);
    chk(r_data[r0+3] == rd_pat(32'h7000, 3) && r_last[r0+3], "R3 fill drains first",
        r_data[r0+3], rd_pat(32'h7000, 3));
    chk(r_data[r0+4] == rd_pat(32'h8008, 0), "R7 read after fill", r_data[r0+4], rd_pat(32'h8008, 0));
    chk(r_data[r0+5] == rd_pat(32'h9000, 0), "R8 third last", r_data[r0+5], rd_pat(32'h9000, 0));
  endtask

  task automatic t_error;
    int r0 = r_n; bit m;
    err_tr = acc_n; err_beat = 1;
    send(3'd3, 32'h0000_A000, 3'd0, '0, m);
    send(3'd0, 32'h0000_B000, 3'd4, '0, m);
    wait_rsp(r0 + 3);
    repeat (5) @(negedge clk);
    chk(r_n - r0 == 3, "R9 beats dropped", 64'(r_n - r0), 64'd3);
    chk(r_err[r0+1] && r_last[r0+1] && r_beat[r0+1] == 2'd1, "R9 err ends",
        {r_err[r0+1], r_last[r0+1]}, 64'b11);
    chk(!r_err[r0+2] && r_data[r0+2] == rd_pat(32'hB000, 0), "R9 next ok",
        r_data[r0+2], rd_pat(32'hB000, 0));
    err_tr = -1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_single_read();
    t_writes();
    t_misalign();
    t_fill();
    t_copyback();
    t_hold();
    t_pipeline();
    t_error();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule